// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This block moves a block of words between one peripheral and memory without the CPU touching each word. Software loads a word count and a starting word address and picks a direction. It then writes a start command through four memory-mapped registers. The controller waits for the device to signal that it is ready. For each word it takes the shared memory bus for exactly one cycle, and it drives the address, the write enable and the write data itself. A small fixed-priority arbiter inside the block always gives the bus to the controller over the CPU, so the CPU is stalled for that single cycle only.

Between two words the controller drops its bus request for at least one cycle, so the CPU keeps making progress during a long transfer. No interrupt is raised per word. The interrupt line is a level that rises only when the count reaches zero or when the device reports an error. It stays high until software acknowledges it.

Top module: `dma_steal`

## Requirements
- R1: Register select 0 is the word count, 1 the word address, 2 the data buffer and 3 the status word. Status bits are: bit 0 busy (read-only), bit 1 done, bit 2 error, bit 3 direction (1 = memory to device, 0 = device to memory), bit 4 start (write-only, reads 0). After reset every register reads 0 and the interrupt is low.
- R2: A start command issued while the count is 0 sets done (and the interrupt) on the next cycle, leaves busy low and makes no bus request.
- R3: Whenever the controller requests the bus, the CPU grant is low and the memory bus carries the controller's access.
- R4: The controller never holds the memory bus in two consecutive cycles, so a CPU that requests continuously is stalled exactly once per transferred word.
- R5: Device to memory: each word taken from the device is written to consecutive word addresses, starting at the programmed address, in the order the device supplied them.
- R6: Memory to device: words read from consecutive addresses are presented on the device data output, in address order, in the cycle where the acknowledge is high.
- R7: After each word the address register rises by one and the count falls by one. When the count reaches 0, done is set and busy clears.
- R8: The interrupt equals done OR error. It stays low while a transfer is busy, and writing 1 to the done or error bit clears that bit.
- R9: A device error seen while the controller waits for the next word aborts the transfer: busy clears, error and the interrupt rise, and the count and address show the words not moved.
- R10: While busy, writes to the count, address, data buffer and direction have no effect.
- R11: When the controller is not requesting, a CPU request is granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Selected register contents |
| cpu_req | input | 1 | CPU memory request |
| cpu_we | input | 1 | CPU write enable |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_gnt | output | 1 | CPU owns the bus this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after a read |
| dev_req | input | 1 | Device ready for the next word |
| dev_wdata | input | DATA_W | Word from the device |
| dev_rdata | output | DATA_W | Word to the device |
| dev_ack | output | 1 | One word finished with the device |
| dev_err | input | 1 | Device error |
| irq | output | 1 | Completion or error interrupt |

## Verification
A zero-length start is probed: a design that launched the engine anyway would steal a cycle and move a stray word, and one that forgot it would never interrupt. A CPU that requests in every cycle is counted against the word count. A controller that held the bus across words would show two stalls in a row, and one that lost priority would show fewer stalls than words. An error is injected after exactly three words with the device idle, so an off-by-one in the count or address update, or an abort that forgot to raise the interrupt, shows in the readback. Mid-transfer register writes catch a controller that let software retarget a live transfer.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    localparam logic [1:0] SEL_COUNT = 2'd0;
    localparam logic [1:0] SEL_ADDR  = 2'd1;
    localparam logic [1:0] SEL_DATA  = 2'd2;
    localparam logic [1:0] SEL_CTRL  = 2'd3;

    localparam int BIT_BUSY = 0;
    localparam int BIT_DONE = 1;
    localparam int BIT_ERR  = 2;
    localparam int BIT_DIR  = 3;
    localparam int BIT_GO   = 4;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_WAIT,
        ENG_BUS,
        ENG_CAPT,
        ENG_GAP
    } eng_state_t;

    typedef struct packed {
        logic step;
        logic buf_load;
        logic buf_from_mem;
        logic finish;
        logic fail;
        logic dev_ack;
    } eng_ctl_t;

    function automatic logic [3:0] pack_status(logic busy, logic done,
                                               logic err, logic dir);
        return {dir, err, done, busy};
    endfunction

endpackage

// File: rtl/dma_engine.sv
module dma_engine
    import dma_steal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  logic     dir,
    input  logic     cnt_last,
    input  logic     dev_req,
    input  logic     dev_err,
    output logic     busy,
    output logic     dma_req,
    output logic     dma_we,
    output eng_ctl_t ctl
);

    eng_state_t st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= ENG_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ENG_IDLE: if (go) st_nx = ENG_WAIT;
            ENG_WAIT: begin
                if (dev_err)      st_nx = ENG_IDLE;
                else if (dev_req) st_nx = ENG_BUS;
            end
            ENG_BUS:  st_nx = dir ? ENG_CAPT : ENG_GAP;
            ENG_CAPT: st_nx = ENG_GAP;
            ENG_GAP:  st_nx = cnt_last ? ENG_IDLE : ENG_WAIT;
            default:  st_nx = ENG_IDLE;
        endcase
    end

    always_comb begin
        ctl              = '0;
        ctl.step         = (st == ENG_GAP);
        ctl.dev_ack      = (st == ENG_GAP);
        ctl.finish       = (st == ENG_GAP) && cnt_last;
        ctl.fail         = (st == ENG_WAIT) && dev_err;
        ctl.buf_from_mem = (st == ENG_CAPT);
        ctl.buf_load     = (st == ENG_CAPT) ||
                           ((st == ENG_WAIT) && dev_req && !dev_err && !dir);
    end

    assign busy    = (st != ENG_IDLE);
    assign dma_req = (st == ENG_BUS);
    assign dma_we  = !dir;

endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  eng_ctl_t          ctl,
    input  logic [DATA_W-1:0] buf_in,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] buffer,
    output logic              dir,
    output logic              go,
    output logic              cnt_last,
    output logic              irq
);

    logic done, err;
    logic ctrl_wr, start_cmd;

    assign ctrl_wr   = wr && (sel == SEL_CTRL);
    assign start_cmd = ctrl_wr && wdata[BIT_GO] && !busy;
    assign go        = start_cmd && (count != '0);
    assign cnt_last  = (count == CNT_W'(1));
    assign irq       = done || err;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            addr   <= '0;
            buffer <= '0;
            dir    <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (wr && !busy) begin
                unique case (sel)
                    SEL_COUNT: count  <= wdata[CNT_W-1:0];
                    SEL_ADDR:  addr   <= wdata[ADDR_W-1:0];
                    SEL_DATA:  buffer <= wdata;
                    SEL_CTRL:  dir    <= wdata[BIT_DIR];
                    default:   ;
                endcase
            end
            if (ctrl_wr && wdata[BIT_DONE]) done <= 1'b0;
            if (ctrl_wr && wdata[BIT_ERR])  err  <= 1'b0;
            if (start_cmd) begin
                done <= (count == '0);
                err  <= 1'b0;
            end
            if (ctl.step) begin
                count <= count - CNT_W'(1);
                addr  <= addr + ADDR_W'(1);
            end
            if (ctl.buf_load) buffer <= buf_in;
            if (ctl.finish)   done   <= 1'b1;
            if (ctl.fail)     err    <= 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_COUNT: rdata = DATA_W'(count);
            SEL_ADDR:  rdata = DATA_W'(addr);
            SEL_DATA:  rdata = buffer;
            default:   rdata = DATA_W'(pack_status(busy, done, err, dir));
        endcase
    end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    assign cpu_gnt = cpu_req && !dma_req;

    always_comb begin
        if (dma_req) begin
            mem_en    = 1'b1;
            mem_we    = dma_we;
            mem_addr  = dma_addr;
            mem_wdata = dma_wdata;
        end else begin
            mem_en    = cpu_req;
            mem_we    = cpu_req && cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end
    end

endmodule

// File: rtl/dma_steal.sv
module dma_steal
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_req,
    input  logic [DATA_W-1:0] dev_wdata,
    output logic [DATA_W-1:0] dev_rdata,
    output logic              dev_ack,
    input  logic              dev_err,
    output logic              irq
);

    logic              busy, dma_req, dma_we, go, dir, cnt_last;
    logic              step;
    eng_ctl_t          ctl;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] buffer, buf_in;

    assign buf_in    = ctl.buf_from_mem ? mem_rdata : dev_wdata;
    assign step      = ctl.step;
    assign dev_ack   = ctl.dev_ack;
    assign dev_rdata = buffer;

    dma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .ctl(ctl), .buf_in(buf_in),
        .count(count), .addr(addr), .buffer(buffer), .dir(dir), .go(go),
        .cnt_last(cnt_last), .irq(irq)
    );

    dma_engine u_eng (
        .clk(clk), .rst(rst), .go(go), .dir(dir), .cnt_last(cnt_last),
        .dev_req(dev_req), .dev_err(dev_err), .busy(busy),
        .dma_req(dma_req), .dma_we(dma_we), .ctl(ctl)
    );

    dma_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(addr),
        .dma_wdata(buffer), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_gnt(cpu_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

endmodule

// File: rtl/dma_steal_checker.sv
module dma_steal_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             dma_req,
    input logic             cpu_req,
    input logic             cpu_gnt,
    input logic             mem_en,
    input logic             busy,
    input logic             irq,
    input logic             step,
    input logic [CNT_W-1:0] count
);

    assert_dma_wins_R3: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (!cpu_gnt && mem_en));

    assert_bus_gap_R4: assert property (@(posedge clk) disable iff (rst)
        dma_req |=> !dma_req);

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        step |=> (count == CNT_W'($past(count) - CNT_W'(1))));

    assert_finish_R7: assert property (@(posedge clk) disable iff (rst)
        (step && count == CNT_W'(1)) |=> (!busy && irq));

    assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !irq);

    assert_cpu_free_R11: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !dma_req) |-> cpu_gnt);

endmodule

bind dma_steal dma_steal_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .dma_req(dma_req), .cpu_req(cpu_req),
    .cpu_gnt(cpu_gnt), .mem_en(mem_en), .busy(busy), .irq(irq),
    .step(step), .count(count)
);

// File: tb/dma_steal_bench.sv
module dma_steal_bench;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          cpu_req = 1'b1;
    logic          cpu_gnt;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          dev_req, dev_ack, dev_err = 1'b0;
    logic [DW-1:0] dev_wdata, dev_rdata;
    logic          irq;

    logic [DW-1:0] mem  [64];
    logic [DW-1:0] src  [64];
    logic [DW-1:0] sink [64];
    int            src_idx = 0, sink_n = 0;
    logic          cur_dir = 1'b0;
    logic          auto_dev = 1'b0, rnd_req = 1'b0, man_req = 1'b0;
    int            stalls = 0, back2back = 0, bad_addr = 0;
    logic          prev_stall = 1'b0;
    int            checks = 0, errors = 0, cycles = 0;

    always #2 clk = ~clk;

    dma_steal #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(16)) u_dma_steal (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_req(cpu_req),
        .cpu_we(1'b0), .cpu_addr(16'd63), .cpu_wdata('0), .cpu_gnt(cpu_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_req(dev_req),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ack(dev_ack),
        .dev_err(dev_err), .irq(irq)
    );

    assign dev_req   = auto_dev ? rnd_req : man_req;
    assign dev_wdata = src[src_idx[5:0]];

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[5:0]];
        end
        if (dev_ack && !cur_dir) src_idx <= src_idx + 1;
        if (dev_ack && cur_dir) begin
            sink[sink_n[5:0]] <= dev_rdata;
            sink_n <= sink_n + 1;
        end
    end

    always @(negedge clk) begin
        rnd_req <= ($urandom % 4) != 0;
        if (!rst) begin
            if (cpu_req && !cpu_gnt) begin
                stalls = stalls + 1;
                if (prev_stall) back2back = back2back + 1;
                if (mem_addr == 16'd63) bad_addr = bad_addr + 1;
                prev_stall = 1'b1;
            end else begin
                prev_stall = 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL R7 watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] sel, logic [DW-1:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] sel, output logic [DW-1:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    function automatic logic [DW-1:0] status_word(logic busy, logic done,
                                                  logic err, logic dir);
        return {28'd0, dir, err, done, busy};
    endfunction

    task automatic clear_counts();
        stalls = 0; back2back = 0; bad_addr = 0;
    endtask

    task automatic run_xfer(logic dir, int base, int n, logic poke);
        logic [DW-1:0] v;
        int mism;
        cur_dir = dir;
        src_idx = 0; sink_n = 0;
        for (int i = 0; i < n; i++) begin
            src[i] = $urandom;
            mem[base + i] = $urandom;
        end
        reg_write(2'd0, DW'(n));
        reg_write(2'd1, DW'(base));
        reg_write(2'd3, status_word(1'b0, 1'b0, 1'b0, dir));
        clear_counts();
        auto_dev = 1'b1;
        reg_write(2'd3, status_word(1'b0, 1'b0, 1'b0, dir) | 32'h10);
        if (poke) begin
            reg_write(2'd0, 32'd40);
            reg_write(2'd1, 32'd50);
            reg_write(2'd3, status_word(1'b0, 1'b0, 1'b0, !dir));
        end
        while (!irq) @(negedge clk);
        auto_dev = 1'b0;
        mism = 0;
        for (int i = 0; i < n; i++) begin
            if (!dir && mem[base + i] !== src[i]) mism++;
            if (dir && (i >= sink_n || sink[i] !== mem[base + i])) mism++;
        end
        chk(dir ? "R6 words delivered" : "R5 words stored", DW'(mism), '0);
        if (dir) chk("R6 word count", DW'(sink_n), DW'(n));
        else     chk("R5 word count", DW'(src_idx), DW'(n));
        reg_read(2'd0, v); chk("R7 count zero", v, '0);
        reg_read(2'd1, v); chk("R7 address end", v, DW'(base + n));
        reg_read(2'd3, v); chk("R7 status done", v, status_word(1'b0, 1'b1, 1'b0, dir));
        chk("R4 stalls per word", DW'(stalls), DW'(n));
        chk("R4 no back-to-back", DW'(back2back), '0);
        chk("R3 bus owner", DW'(bad_addr), '0);
        if (poke) chk("R10 ignored writes", DW'(mism), '0);
        reg_write(2'd3, status_word(1'b0, 1'b1, 1'b0, dir));
        @(negedge clk);
        chk("R8 done cleared", DW'(irq), '0);
    endtask

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            mem[i] = '0; src[i] = '0; sink[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reg_read(2'd3, v); chk("R1 reset status", v, '0);
        reg_read(2'd0, v); chk("R1 reset count", v, '0);
        reg_read(2'd1, v); chk("R1 reset address", v, '0);
        chk("R1 reset irq", DW'(irq), '0);
        chk("R11 idle grant", DW'(cpu_gnt), 32'd1);

        reg_write(2'd2, 32'hA5A5_0001);
        reg_read(2'd2, v); chk("R1 buffer write", v, 32'hA5A5_0001);

        clear_counts();
        reg_write(2'd3, 32'h10);
        reg_read(2'd3, v); chk("R2 zero start done", v, status_word(1'b0, 1'b1, 1'b0, 1'b0));
        chk("R2 zero start irq", DW'(irq), 32'd1);
        repeat (4) @(negedge clk);
        chk("R2 no bus request", DW'(stalls), '0);
        reg_write(2'd3, 32'h2);
        @(negedge clk);
        chk("R8 clear after zero start", DW'(irq), '0);

        run_xfer(1'b0, 5, 6, 1'b1);
        run_xfer(1'b1, 20, 1, 1'b0);
        run_xfer(1'b1, 3, 9, 1'b1);
        for (int it = 0; it < 6; it++) begin
            run_xfer(it[0], int'($urandom % 32), 1 + int'($urandom % 16), 1'b0);
        end

        cur_dir = 1'b0;
        src_idx = 0;
        for (int i = 0; i < 8; i++) src[i] = $urandom;
        reg_write(2'd0, 32'd8);
        reg_write(2'd1, 32'd10);
        reg_write(2'd3, 32'h0);
        man_req = 1'b1;
        reg_write(2'd3, 32'h10);
        while (src_idx < 3) @(negedge clk);
        man_req = 1'b0;
        chk("R8 no irq mid transfer", DW'(irq), '0);
        dev_err = 1'b1;
        repeat (2) @(negedge clk);
        dev_err = 1'b0;
        reg_read(2'd3, v); chk("R9 error status", v, status_word(1'b0, 1'b0, 1'b1, 1'b0));
        chk("R9 error irq", DW'(irq), 32'd1);
        reg_read(2'd0, v); chk("R9 remaining count", v, 32'd5);
        reg_read(2'd1, v); chk("R9 next address", v, 32'd13);
        chk("R9 words before abort", DW'((mem[10] === src[0]) && (mem[11] === src[1]) &&
                                          (mem[12] === src[2])), 32'd1);
        reg_write(2'd3, 32'h4);
        @(negedge clk);
        chk("R8 error cleared", DW'(irq), '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule